// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Controller

This block gathers interrupt events from three source lanes. Two lanes belong to the SCSI side and one to the DMA side. Each lane has a visible status register and a hidden shadow register of the same width. The visible registers form the first level of the interrupt stack. The shadow registers form the second level. While an interrupt is outstanding in the first level, newly arriving events are held back in the shadow level. When software has serviced the first level, the controller releases the pin for a guaranteed quiet gap. It then moves the shadow contents into the visible registers and raises the pin again.

Each bit has an enable and a fatal/nonfatal class. A bit is *stackable* when it is enabled or fatal.

Events on a masked nonfatal bit still appear in the visible register. They raise no pending flag and no pin, so they never cause stacking.

A fatal bit raises a halt output for the script engine whatever its enable says. Masking a fatal bit only suppresses the pin.

A global pin-disable input stops new pin assertions. It leaves the polling flags untouched.

Software reads the visible status registers through a select-and-strobe port. The read clears the register it selects.

Top module: `irq_stack_ctrl`

## Requirements
- R1: Out of reset, `irq_n` is 1, `scsi_pend`, `dma_pend` and `halt` are 0, and every visible status register reads 0.
- R2: With nothing pending and the shadow level empty, an event on a stackable bit sets that bit in the visible register on the next cycle. The same cycle, it sets `scsi_pend` (lanes 0 and 1) or `dma_pend` (lane 2). The `rd_sel` encoding is 0 = SCSI status 0, 1 = SCSI status 1, 2 = DMA status, 3 = none.
- R3: While a visible register holds an enabled bit and the pin is not disabled, `irq_n` is low from the cycle after that bit becomes visible. It returns high one cycle after the last enabled visible bit is cleared.
- R4: An event on a bit that is neither enabled nor fatal sets its visible bit. It does not set a pending flag or drive `irq_n` low, and a following stackable event still lands in the visible level.
- R5: While any pending flag is set or the shadow level is non-empty, stackable events go to the shadow registers and leave the visible registers unchanged.
- R6: Further events on a non-empty shadow level are OR-ed into it. No shadow bit is lost until promotion.
- R7: Strobing `rd_en` returns the selected visible register on `rd_data` in the same cycle and clears it on the next cycle. Selecting 3 returns 0 and clears nothing.
- R8: Once no stackable visible bit remains and the shadow level is non-empty, `irq_n` stays high for at least GAP_CYC cycles. Only then does the shadow content move into the visible registers, after which the pin is asserted again.
- R9: With `pin_dis` set, a high `irq_n` stays high, and an already low `irq_n` stays low until its interrupt is serviced. The pending flags are not affected by `pin_dis`.
- R10: An event on a fatal bit sets `halt` on the next cycle, whether or not that bit is enabled and whichever level it lands in. `halt` falls once no fatal bit remains in either level.
- R11: An event arriving in the same cycle as a read that clears the last stackable visible bit goes to the visible level if the shadow level is empty, and to the shadow level otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_scsi0 | input | LANE_W | Event pulses, SCSI status 0 lane |
| evt_scsi1 | input | LANE_W | Event pulses, SCSI status 1 lane |
| evt_dma | input | LANE_W | Event pulses, DMA status lane |
| en_scsi0 | input | LANE_W | Per-bit enable (1 = unmasked), SCSI status 0 |
| en_scsi1 | input | LANE_W | Per-bit enable, SCSI status 1 |
| en_dma | input | LANE_W | Per-bit enable, DMA status |
| fatal_scsi0 | input | LANE_W | Per-bit fatal class (1 = fatal), SCSI status 0 |
| fatal_scsi1 | input | LANE_W | Per-bit fatal class, SCSI status 1 |
| fatal_dma | input | LANE_W | Per-bit fatal class, DMA status |
| pin_dis | input | 1 | Blocks new assertions of `irq_n` |
| rd_en | input | 1 | Read strobe, clears the selected register |
| rd_sel | input | 2 | Register select (0 SCSI0, 1 SCSI1, 2 DMA, 3 none) |
| rd_data | output | LANE_W | Selected visible status register |
| irq_n | output | 1 | Active-low interrupt pin |
| scsi_pend | output | 1 | A stackable bit is visible in a SCSI register |
| dma_pend | output | 1 | A stackable bit is visible in the DMA register |
| halt | output | 1 | Stop request to the script engine |

## Verification
The assertions assume that the enable and fatal configuration is quasi-static. A bit's class must not change while that bit sits in either level, because the shadow-retention and halt properties judge bits by the class in force at that moment. The stimulus respects this: it reprograms the enable and fatal inputs only straight after a reset, or while both levels are empty. Events are single-cycle pulses applied away from the clock edge. The read strobe is never held for more than one cycle at a time.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        SEL_SCSI0 = 2'd0,
        SEL_SCSI1 = 2'd1,
        SEL_DMA   = 2'd2,
        SEL_NONE  = 2'd3
    } lane_sel_e;

    typedef struct packed {
        logic pend;        // stackable bit visible now
        logic pin_req;     // enabled bit visible now
        logic fatal;       // fatal bit in either level
        logic shd_any;     // shadow level non-empty
        logic busy_kept;   // stackable bit visible after this cycle's clear
    } lane_flags_t;

    function automatic logic sel_hits(input lane_sel_e sel, input int lane);
        return (sel != SEL_NONE) && (int'(sel) == lane);
    endfunction

endpackage

// File: rtl/irq_lane.sv
module irq_lane
    import irq_stack_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     evt,
    input  logic [W-1:0]     en,
    input  logic [W-1:0]     fatal,
    input  logic             clr,
    input  logic             to_shadow,
    input  logic             promote,
    output logic [W-1:0]     vis,
    output logic [W-1:0]     shd,
    output lane_flags_t      flags
);

    logic [W-1:0] stk;
    logic [W-1:0] vis_kept;
    logic [W-1:0] land_vis;
    logic [W-1:0] land_shd;

    always_comb begin
        stk      = en | fatal;
        vis_kept = clr ? '0 : vis;
        land_vis = evt & (~stk | {W{~to_shadow}});
        land_shd = evt & stk & {W{to_shadow}};

        flags.pend      = |(vis & stk);
        flags.pin_req   = |(vis & en);
        flags.fatal     = |((vis | shd) & fatal);
        flags.shd_any   = |shd;
        flags.busy_kept = |(vis_kept & stk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis <= '0;
            shd <= '0;
        end else begin
            vis <= vis_kept | land_vis | (promote ? shd : '0);
            shd <= (promote ? '0 : shd) | land_shd;
        end
    end

endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
    parameter int GAP_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic l1_idle,
    input  logic shd_any,
    input  logic pin_high,
    output logic promote
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt;
    logic          arm;

    always_comb begin
        arm     = l1_idle && shd_any && pin_high;
        promote = arm && (cnt == CW'(GAP_CYC - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !arm || promote) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic pin_dis,
    output logic irq_n
);

    logic drive_low;

    always_comb drive_low = req && (!irq_n || !pin_dis);

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= !drive_low;
    end

endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl
    import irq_stack_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int GAP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] evt_scsi0,
    input  logic [LANE_W-1:0] evt_scsi1,
    input  logic [LANE_W-1:0] evt_dma,
    input  logic [LANE_W-1:0] en_scsi0,
    input  logic [LANE_W-1:0] en_scsi1,
    input  logic [LANE_W-1:0] en_dma,
    input  logic [LANE_W-1:0] fatal_scsi0,
    input  logic [LANE_W-1:0] fatal_scsi1,
    input  logic [LANE_W-1:0] fatal_dma,
    input  logic              pin_dis,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [LANE_W-1:0] rd_data,
    output logic              irq_n,
    output logic              scsi_pend,
    output logic              dma_pend,
    output logic              halt
);

    localparam int FLAT_W = NUM_LANES * LANE_W;

    logic [LANE_W-1:0] evt_a   [NUM_LANES];
    logic [LANE_W-1:0] en_a    [NUM_LANES];
    logic [LANE_W-1:0] fat_a   [NUM_LANES];
    logic [LANE_W-1:0] vis_a   [NUM_LANES];
    logic [LANE_W-1:0] shd_a   [NUM_LANES];
    lane_flags_t       flg_a   [NUM_LANES];
    logic [NUM_LANES-1:0] clr_v;

    logic        to_shadow;
    logic        promote;
    logic        pin_req;
    logic        shd_any;
    logic        busy_kept;
    logic        l1_idle;
    logic        fatal_any;
    lane_sel_e   sel;

    // Flattened views used by the bound checker.
    logic [FLAT_W-1:0] evt_flat;
    logic [FLAT_W-1:0] stk_flat;
    logic [FLAT_W-1:0] fat_flat;
    logic [FLAT_W-1:0] shd_flat;

    always_comb begin
        evt_a[0] = evt_scsi0;   evt_a[1] = evt_scsi1;   evt_a[2] = evt_dma;
        en_a[0]  = en_scsi0;    en_a[1]  = en_scsi1;    en_a[2]  = en_dma;
        fat_a[0] = fatal_scsi0; fat_a[1] = fatal_scsi1; fat_a[2] = fatal_dma;
        sel      = lane_sel_e'(rd_sel);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            assign clr_v[g] = rd_en && sel_hits(sel, g);

            irq_lane #(.W(LANE_W)) lane_i (
                .clk       (clk),
                .rst       (rst),
                .evt       (evt_a[g]),
                .en        (en_a[g]),
                .fatal     (fat_a[g]),
                .clr       (clr_v[g]),
                .to_shadow (to_shadow),
                .promote   (promote),
                .vis       (vis_a[g]),
                .shd       (shd_a[g]),
                .flags     (flg_a[g])
            );

            assign evt_flat[g*LANE_W +: LANE_W] = evt_a[g];
            assign stk_flat[g*LANE_W +: LANE_W] = en_a[g] | fat_a[g];
            assign fat_flat[g*LANE_W +: LANE_W] = fat_a[g];
            assign shd_flat[g*LANE_W +: LANE_W] = shd_a[g];
        end
    endgenerate

    always_comb begin
        pin_req   = 1'b0;
        shd_any   = 1'b0;
        busy_kept = 1'b0;
        fatal_any = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            pin_req   |= flg_a[i].pin_req;
            shd_any   |= flg_a[i].shd_any;
            busy_kept |= flg_a[i].busy_kept;
            fatal_any |= flg_a[i].fatal;
        end
        scsi_pend = flg_a[0].pend || flg_a[1].pend;
        dma_pend  = flg_a[2].pend;
        l1_idle   = !(scsi_pend || dma_pend);
        to_shadow = shd_any || busy_kept;
        halt      = fatal_any;
    end

    always_comb begin
        case (sel)
            SEL_SCSI0: rd_data = vis_a[0];
            SEL_SCSI1: rd_data = vis_a[1];
            SEL_DMA:   rd_data = vis_a[2];
            default:   rd_data = '0;
        endcase
    end

    irq_gap_timer #(.GAP_CYC(GAP_CYC)) gap_i (
        .clk      (clk),
        .rst      (rst),
        .l1_idle  (l1_idle),
        .shd_any  (shd_any),
        .pin_high (irq_n),
        .promote  (promote)
    );

    irq_pin_drv pin_i (
        .clk     (clk),
        .rst     (rst),
        .req     (pin_req),
        .pin_dis (pin_dis),
        .irq_n   (irq_n)
    );

endmodule

// File: rtl/irq_stack_chk.sv
module irq_stack_chk #(
    parameter int FLAT_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [FLAT_W-1:0] evt_flat,
    input logic [FLAT_W-1:0] stk_flat,
    input logic [FLAT_W-1:0] fat_flat,
    input logic [FLAT_W-1:0] shd_flat,
    input logic              promote,
    input logic              pin_req,
    input logic              pin_dis,
    input logic              irq_n,
    input logic              scsi_pend,
    input logic              dma_pend,
    input logic              halt
);

    // R3: the pin only goes low when an enabled visible bit was present.
    p_pin_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(pin_req));

    // R2: a stackable event always leaves a trace in a pending flag or the shadow.
    p_event_recorded_r2: assert property (@(posedge clk) disable iff (rst)
        (|(evt_flat & stk_flat)) |=> (scsi_pend || dma_pend || (|shd_flat)));

    // R6: shadow bits are never lost except by promotion.
    p_shadow_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        !promote |=> ((shd_flat & $past(shd_flat)) == $past(shd_flat)));

    // R8: promotion happens only with the pin high for the quiet gap (default 3).
    p_gap_before_promote_r8: assert property (@(posedge clk) disable iff (rst)
        promote |-> (irq_n && $past(irq_n) && $past(irq_n, 2)));

    // R8: promotion requires an idle first level.
    p_promote_idle_r8: assert property (@(posedge clk) disable iff (rst)
        promote |-> !(scsi_pend || dma_pend));

    // R9: disabled pin is never newly asserted.
    p_pin_dis_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (pin_dis && irq_n) |=> irq_n);

    // R10: a fatal event raises halt on the next cycle.
    p_fatal_halts_r10: assert property (@(posedge clk) disable iff (rst)
        (|(evt_flat & fat_flat)) |=> halt);

endmodule

bind irq_stack_ctrl irq_stack_chk #(.FLAT_W(FLAT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .evt_flat  (evt_flat),
    .stk_flat  (stk_flat),
    .fat_flat  (fat_flat),
    .shd_flat  (shd_flat),
    .promote   (promote),
    .pin_req   (pin_req),
    .pin_dis   (pin_dis),
    .irq_n     (irq_n),
    .scsi_pend (scsi_pend),
    .dma_pend  (dma_pend),
    .halt      (halt)
);

// File: tb/irq_stack_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_stack_ctrl_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] ev [3];
    logic [W-1:0] en [3];
    logic [W-1:0] ft [3];
    logic         pin_dis;
    logic         rd_en;
    logic [1:0]   rd_sel;
    logic [W-1:0] rd_data;
    logic         irq_n, scsi_pend, dma_pend, halt;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irq_stack_ctrl #(.LANE_W(W), .GAP_CYC(3)) dut_i (
        .clk(clk), .rst(rst),
        .evt_scsi0(ev[0]), .evt_scsi1(ev[1]), .evt_dma(ev[2]),
        .en_scsi0(en[0]), .en_scsi1(en[1]), .en_dma(en[2]),
        .fatal_scsi0(ft[0]), .fatal_scsi1(ft[1]), .fatal_dma(ft[2]),
        .pin_dis(pin_dis), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_n(irq_n),
        .scsi_pend(scsi_pend), .dma_pend(dma_pend), .halt(halt)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; pin_dis = 1'b0; rd_en = 1'b0; rd_sel = 2'd3;
        for (int i = 0; i < 3; i++) begin ev[i] = '0; en[i] = '0; ft[i] = '0; end
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic read_lane(input int l, input string req, input int exp);
        rd_sel = 2'(l);
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic clear_lane(input int l);
        rd_sel = 2'(l); rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 scsi_pend", int'(scsi_pend), 0);
        chk("R1 dma_pend", int'(dma_pend), 0);
        chk("R1 halt", int'(halt), 0);
        for (int l = 0; l < 3; l++) read_lane(l, "R1 status", 0);

        // Sweep: every lane, bit and enable/fatal class (R2 R3 R4 R7 R10)
        for (int l = 0; l < 3; l++) begin
            for (int b = 0; b < W; b++) begin
                for (int c = 0; c < 4; c++) begin
                    automatic int e = c & 1;
                    automatic int f = (c >> 1) & 1;
                    automatic int stk = e | f;
                    do_reset();
                    en[l] = e ? W'(1 << b) : '0;
                    ft[l] = f ? W'(1 << b) : '0;
                    ev[l] = W'(1 << b);
                    tick();
                    ev[l] = '0;
                    read_lane(l, "R2 visible bit", 1 << b);
                    chk("R2 scsi_pend", int'(scsi_pend), (l < 2) ? stk : 0);
                    chk("R2 dma_pend", int'(dma_pend), (l == 2) ? stk : 0);
                    chk("R10 halt", int'(halt), f);
                    tick();
                    chk(e ? "R3 irq_n" : "R4 irq_n", int'(irq_n), e ? 0 : 1);
                    clear_lane(l);
                    read_lane(l, "R7 cleared", 0);
                    chk("R7 pend cleared", int'(scsi_pend | dma_pend), 0);
                    chk("R10 halt cleared", int'(halt), 0);
                    tick();
                    chk("R3 irq_n released", int'(irq_n), 1);
                end
            end
        end

        // Stacking, OR-merge and gated promotion (R5 R6 R8)
        do_reset();
        for (int i = 0; i < 3; i++) en[i] = '1;
        ev[0] = 8'h01; tick(); ev[0] = '0; tick();
        chk("R3 irq_n asserted", int'(irq_n), 0);
        ev[2] = 8'h08; tick(); ev[2] = '0;
        read_lane(2, "R5 dma stays clear", 0);
        chk("R5 dma_pend", int'(dma_pend), 0);
        ev[1] = 8'h20; ev[2] = 8'h04; tick(); ev[1] = '0; ev[2] = '0;
        read_lane(1, "R5 scsi1 stays clear", 0);
        clear_lane(0);
        rd_sel = 2'd2;
        begin
            automatic int hi = 0;
            for (int i = 0; i < 12; i++) begin
                if (irq_n) begin
                    hi++;
                    if (hi == 1) begin #1; chk("R8 no early move", int'(rd_data), 0); end
                end else if (hi > 0) begin
                    break;
                end
                tick();
            end
            chk("R8 gap at least 3", int'(hi >= 3), 1);
            chk("R8 gap bounded", int'(hi <= 6), 1);
        end
        chk("R8 pin reasserted", int'(irq_n), 0);
        read_lane(2, "R6 merged dma", 8'h0C);
        read_lane(1, "R8 promoted scsi1", 8'h20);
        chk("R8 dma_pend", int'(dma_pend), 1);

        // Pin disable (R9)
        do_reset();
        en[0] = '1;
        ev[0] = 8'h01; tick(); ev[0] = '0; tick();
        pin_dis = 1'b1; tick();
        chk("R9 asserted pin held", int'(irq_n), 0);
        clear_lane(0); tick();
        chk("R9 released when serviced", int'(irq_n), 1);
        ev[0] = 8'h02; tick(); ev[0] = '0; tick(); tick();
        chk("R9 no new assertion", int'(irq_n), 1);
        chk("R9 pend unaffected", int'(scsi_pend), 1);
        pin_dis = 1'b0; tick();
        chk("R9 asserts after enable", int'(irq_n), 0);

        // Masked nonfatal does not stack (R4)
        do_reset();
        en[2] = '1;
        ev[0] = 8'h01; tick(); ev[0] = '0;
        chk("R4 no pend", int'(scsi_pend), 0);
        ev[2] = 8'h01; tick(); ev[2] = '0;
        read_lane(2, "R4 lands visible", 8'h01);
        read_lane(0, "R4 posted", 8'h01);
        tick();
        chk("R4 pin from dma", int'(irq_n), 0);

        // Same-cycle clear and event, empty shadow (R11)
        do_reset();
        for (int i = 0; i < 3; i++) en[i] = '1;
        ev[0] = 8'h01; tick(); ev[0] = '0; tick();
        ev[1] = 8'h02; clear_lane(0); ev[1] = '0;
        read_lane(1, "R11 visible when shadow empty", 8'h02);
        read_lane(0, "R11 old cleared", 0);
        tick();
        chk("R11 pin still asserted", int'(irq_n), 0);

        // Same-cycle clear and event, shadow occupied (R11)
        do_reset();
        for (int i = 0; i < 3; i++) en[i] = '1;
        ev[0] = 8'h01; tick(); ev[0] = '0;
        ev[2] = 8'h01; tick(); ev[2] = '0;
        ev[1] = 8'h02; clear_lane(0); ev[1] = '0;
        read_lane(1, "R11 stacked behind shadow", 0);
        for (int i = 0; i < 8; i++) tick();
        read_lane(1, "R8 promoted late event", 8'h02);
        read_lane(2, "R8 promoted earlier event", 8'h01);

        // Unused select (R7)
        do_reset();
        en[0] = '1;
        ev[0] = 8'h01; tick(); ev[0] = '0;
        clear_lane(3);
        #1;
        chk("R7 select 3 reads zero", int'(rd_data), 0);
        read_lane(0, "R7 select 3 clears nothing", 8'h01);

        // Fatal held in shadow still halts (R10)
        do_reset();
        en[0] = '1; en[2] = '1; ft[2] = 8'h01;
        ev[0] = 8'h01; tick(); ev[0] = '0;
        chk("R10 no halt yet", int'(halt), 0);
        ev[2] = 8'h01; tick(); ev[2] = '0;
        read_lane(2, "R5 fatal stacked", 0);
        chk("R10 halt from shadow", int'(halt), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule